// File: doc/BRIEF.md
# Frame-Synchronous Register List Engine

This block replays a batch of register writes at a frame boundary. Software builds a list in memory. Each entry of the list is a pair of 32-bit words: the word index of a target register, then the value to write there. Software gives every channel a first-word address and an inclusive last-word address and arms the channel. On the next vsync pulse the engine walks each armed channel's list through a memory read port. It replays every entry as one write on a register-bus master port, then sets that channel's done flag.

There are eight channels. When one vsync triggers several channels, they are serviced one after another. Only one memory read or one register write is outstanding at any time. The last-word address can be moved forward while a channel waits for its vsync, which adds more entries to the batch. A level interrupt reports finished channels whose trigger is enabled.

The memory request, the memory response and the register-bus write are valid/ready streams. A beat transfers on a cycle where both valid and ready are high. While valid is high and ready is low, the sender holds valid and the payload unchanged, so the receiving side can stall any stream for as long as it needs. The control-register port and vsync are plain pins.

Top module: `rdl_engine`

## Requirements
- R1: After reset, every control register reads 0, no done flag is set, irq is low, and no memory or register-bus valid is raised.
- R2: Each entry is two consecutive words at byte addresses A and A+4. Word A is issued on reg_addr and word A+4 on reg_data. Entries are replayed in ascending address order, and every memory read address is word aligned.
- R3: A channel is armed only when both its trigger bit and its write bit are set. A vsync pulse starts every armed channel. Channels 0..6 use AUTO (csr_addr 16): trigger bits [6:0] and write bits [14:8]. Channel 7 uses bit 0 of AUTO2 (csr_addr 17) as its write bit and bit 0 of AUTO3 (csr_addr 18) as its trigger bit.
- R4: Start addresses are at csr_addr 0..7 and last-word addresses at csr_addr 8..15, one per channel. An entry at address A is replayed while A <= last-word address. A start above the last-word address sets done and issues no write.
- R5: Rewriting the last-word address of an armed channel before its vsync makes that vsync replay every entry from the start address up to the new last-word address.
- R6: Channels triggered by the same vsync run one at a time, lowest index first.
- R7: A vsync that arrives while a channel is still running its list is ignored for that channel and is not queued.
- R8: Clearing the trigger bit of a running channel lets it finish its list and set its done flag.
- R9: Done flags read at STATUS (csr_addr 20) bits [7:0]. Writing CTRL (csr_addr 19) with bit k set in [7:0] clears done flag k, and writing 0xFF clears all of them. That field reads back as 0.
- R10: irq is high exactly while some channel has both its done flag and its trigger bit set.
- R11: Under back-pressure, mem_req_valid, reg_valid and their payloads stay unchanged until accepted.
- R12: CTRL bit 8 (read urgent) and bit 9 (write urgent) are stored and read back. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame-boundary pulse, one cycle high |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 5 | Control register word index |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory byte address to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_data | input | 32 | Memory read data |
| reg_valid | output | 1 | Register write valid |
| reg_ready | input | 1 | Register write accepted |
| reg_addr | output | 32 | Target register word index |
| reg_data | output | 32 | Target register value |
| irq | output | 1 | Level interrupt |

## Verification
The checker assumes that the memory model returns exactly one response for each accepted request, and only after accepting it. It also assumes that CSR writes never land in the same cycle as a done flag being set for the bit being cleared. The bench's memory model answers each accepted read once, on the following cycle. It keeps all tables word aligned, and it clears done flags only after the channels concerned have finished. Back-pressure comes from ready patterns that toggle on a free-running counter. This lets the hold rules be exercised without the stimulus ever breaking the handshake.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  typedef enum logic [2:0] {
    FS_IDLE, FS_CHECK, FS_AREQ, FS_ARSP, FS_DREQ, FS_DRSP, FS_WRITE, FS_FIN
  } fetch_state_e;

  // offset of the per-channel write bits inside the AUTO register
  localparam int unsigned WR_BIT_OFS = 8;
endpackage

// File: rtl/rdl_csr.sv
module rdl_csr #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CAW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [CAW-1:0]          addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [NCH-1:0]          done_set,
  output logic [NCH-1:0][AW-1:0]  start_o,
  output logic [NCH-1:0][AW-1:0]  last_o,
  output logic [NCH-1:0]          trig_o,
  output logic [NCH-1:0]          wr_o,
  output logic [NCH-1:0]          done_o
);
  import rdl_pkg::*;

  localparam int unsigned END_BASE = NCH;
  localparam int unsigned AUTO_A   = 2 * NCH;
  localparam int unsigned AUTO2_A  = AUTO_A + 1;
  localparam int unsigned AUTO3_A  = AUTO_A + 2;
  localparam int unsigned CTRL_A   = AUTO_A + 3;
  localparam int unsigned STAT_A   = AUTO_A + 4;
  localparam int unsigned LAST     = NCH - 1;

  logic [NCH-1:0][AW-1:0] start_q, last_q;
  logic [NCH-1:0]         trig_q, wr_q, done_q, clr;
  logic                   urg_rd_q, urg_wr_q;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata;
  assign clr = (we && addr == CAW'(CTRL_A)) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      last_q   <= '0;
      trig_q   <= '0;
      wr_q     <= '0;
      done_q   <= '0;
      urg_rd_q <= 1'b0;
      urg_wr_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (we && addr == CAW'(i))            start_q[i] <= wdata[AW-1:0];
        if (we && addr == CAW'(END_BASE + i)) last_q[i]  <= wdata[AW-1:0];
      end
      if (we && addr == CAW'(AUTO_A)) begin
        trig_q[LAST-1:0] <= wdata[LAST-1:0];
        wr_q[LAST-1:0]   <= wdata[WR_BIT_OFS +: LAST];
      end
      if (we && addr == CAW'(AUTO2_A)) wr_q[LAST]   <= wdata[0];
      if (we && addr == CAW'(AUTO3_A)) trig_q[LAST] <= wdata[0];
      if (we && addr == CAW'(CTRL_A)) begin
        urg_rd_q <= wdata[8];
        urg_wr_q <= wdata[9];
      end
      // a finishing channel wins over a clear in the same cycle
      done_q <= (done_q & ~clr) | done_set;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == CAW'(i))            rdata = DW'(start_q[i]);
      if (addr == CAW'(END_BASE + i)) rdata = DW'(last_q[i]);
    end
    if (addr == CAW'(AUTO_A)) begin
      rdata[LAST-1:0]          = trig_q[LAST-1:0];
      rdata[WR_BIT_OFS +: LAST] = wr_q[LAST-1:0];
    end
    if (addr == CAW'(AUTO2_A)) rdata[0] = wr_q[LAST];
    if (addr == CAW'(AUTO3_A)) rdata[0] = trig_q[LAST];
    if (addr == CAW'(CTRL_A)) begin
      rdata[8] = urg_rd_q;
      rdata[9] = urg_wr_q;
    end
    if (addr == CAW'(STAT_A)) rdata[NCH-1:0] = done_q;
  end

  assign start_o = start_q;
  assign last_o  = last_q;
  assign trig_o  = trig_q;
  assign wr_o    = wr_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rdl_arb.sv
module rdl_arb #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vsync,
  input  logic [NCH-1:0] armed,
  input  logic [NCH-1:0] active,
  input  logic           take,
  output logic           gnt_valid,
  output logic [CHW-1:0] gnt_idx
);
  logic [NCH-1:0] pend_q, pend_d;

  always_comb begin
    gnt_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) gnt_idx = CHW'(i);
    end
  end
  assign gnt_valid = |pend_q;

  always_comb begin
    pend_d = pend_q;
    if (vsync) pend_d = pend_d | (armed & ~active);
    pend_d = pend_d & armed;
    if (take) pend_d[gnt_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/rdl_fetch.sv
module rdl_fetch #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gnt_valid,
  input  logic [CHW-1:0]         gnt_idx,
  output logic                   take,
  input  logic [NCH-1:0][AW-1:0] start_i,
  input  logic [NCH-1:0][AW-1:0] last_i,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [AW-1:0]          mem_req_addr,
  input  logic                   mem_rsp_valid,
  output logic                   mem_rsp_ready,
  input  logic [DW-1:0]          mem_rsp_data,
  output logic                   reg_valid,
  input  logic                   reg_ready,
  output logic [DW-1:0]          reg_addr,
  output logic [DW-1:0]          reg_data,
  output logic [NCH-1:0]         active,
  output logic [NCH-1:0]         done_set
);
  import rdl_pkg::*;

  localparam int unsigned WORD_B  = DW / 8;
  localparam int unsigned ENTRY_B = 2 * WORD_B;

  fetch_state_e   st_q, st_d;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  cur_q;
  logic [DW-1:0]  a_q, d_q;

  always_comb begin
    st_d          = st_q;
    take          = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_addr  = cur_q;
    mem_rsp_ready = 1'b0;
    reg_valid     = 1'b0;
    done_set      = '0;
    unique case (st_q)
      FS_IDLE:  if (gnt_valid) begin take = 1'b1; st_d = FS_CHECK; end
      FS_CHECK: st_d = (cur_q > last_i[ch_q]) ? FS_FIN : FS_AREQ;
      FS_AREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = FS_ARSP;
      end
      FS_ARSP: begin
        mem_rsp_ready = 1'b1;
        if (mem_rsp_valid) st_d = FS_DREQ;
      end
      FS_DREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_q + AW'(WORD_B);
        if (mem_req_ready) st_d = FS_DRSP;
      end
      FS_DRSP: begin
        mem_rsp_ready = 1'b1;
        if (mem_rsp_valid) st_d = FS_WRITE;
      end
      FS_WRITE: begin
        reg_valid = 1'b1;
        if (reg_ready) st_d = FS_CHECK;
      end
      FS_FIN: begin
        done_set = NCH'(1) << ch_q;
        st_d     = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      ch_q  <= '0;
      cur_q <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        ch_q  <= gnt_idx;
        cur_q <= start_i[gnt_idx];
      end
      if (st_q == FS_ARSP && mem_rsp_valid) a_q <= mem_rsp_data;
      if (st_q == FS_DRSP && mem_rsp_valid) d_q <= mem_rsp_data;
      if (st_q == FS_WRITE && reg_ready) cur_q <= cur_q + AW'(ENTRY_B);
    end
  end

  assign reg_addr = a_q;
  assign reg_data = d_q;
  assign active   = (st_q != FS_IDLE) ? (NCH'(1) << ch_q) : '0;
endmodule

// File: rtl/rdl_engine.sv
module rdl_engine #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vsync,
  input  logic           csr_we,
  input  logic [CAW-1:0] csr_addr,
  input  logic [DW-1:0]  csr_wdata,
  output logic [DW-1:0]  csr_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           reg_valid,
  input  logic           reg_ready,
  output logic [DW-1:0]  reg_addr,
  output logic [DW-1:0]  reg_data,
  output logic           irq
);
  localparam int unsigned CHW = $clog2(NCH);

  logic [NCH-1:0][AW-1:0] start_w, last_w;
  logic [NCH-1:0]         trig_w, wr_w, done_w, done_set_w, active_w;
  logic                   gnt_valid_w, take_w;
  logic [CHW-1:0]         gnt_idx_w;

  rdl_csr #(.NCH(NCH), .AW(AW), .DW(DW), .CAW(CAW)) u_csr (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
    .rdata(csr_rdata), .done_set(done_set_w), .start_o(start_w), .last_o(last_w),
    .trig_o(trig_w), .wr_o(wr_w), .done_o(done_w)
  );

  rdl_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .armed(trig_w & wr_w),
    .active(active_w), .take(take_w), .gnt_valid(gnt_valid_w), .gnt_idx(gnt_idx_w)
  );

  rdl_fetch #(.NCH(NCH), .AW(AW), .DW(DW), .CHW(CHW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .gnt_valid(gnt_valid_w), .gnt_idx(gnt_idx_w),
    .take(take_w), .start_i(start_w), .last_i(last_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_data(reg_data), .active(active_w), .done_set(done_set_w)
  );

  assign irq = |(done_w & trig_w);
endmodule

// File: rtl/rdl_engine_chk.sv
module rdl_engine_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           csr_we,
  input logic [CAW-1:0] csr_addr,
  input logic [DW-1:0]  csr_wdata,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic           reg_valid,
  input logic           reg_ready,
  input logic [DW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_data,
  input logic           irq,
  input logic [NCH-1:0] done_q,
  input logic [NCH-1:0] done_set
);
  localparam int unsigned CTRL_A = 2 * NCH + 3;

  // R11
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_data));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && csr_addr == CAW'(CTRL_A) && ((csr_wdata[NCH-1:0] & done_set) == '0)
    |=> (done_q & $past(csr_wdata[NCH-1:0])) == '0);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_set) != '0) || $past(csr_we));

  // R6
  one_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_set));
endmodule

bind rdl_engine rdl_engine_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CAW(CAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .reg_valid(reg_valid), .reg_ready(reg_ready),
  .reg_addr(reg_addr), .reg_data(reg_data), .irq(irq), .done_q(done_w),
  .done_set(done_set_w)
);

// File: tb/tb_rdl_engine.sv
module tb_rdl_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_AUTO = 5'd16, A_AUTO2 = 5'd17, A_AUTO3 = 5'd18,
                         A_CTRL = 5'd19, A_STAT = 5'd20;

  logic clk = 1'b0, rst_n = 1'b0, vsync = 1'b0;
  logic csr_we = 1'b0;
  logic [4:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic reg_valid, reg_ready, irq;
  logic [31:0] reg_addr, reg_data;

  logic [31:0] mem [32];
  logic [31:0] lg_a [64], lg_d [64];
  int n_log = 0, n_chk = 0, n_bad = 0;
  logic bp_en = 1'b0;
  logic [3:0] cyc = '0;
  logic done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdl_engine dut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_data(reg_data), .irq(irq)
  );

  assign mem_req_ready = !bp_en || cyc[0];
  assign reg_ready     = !bp_en || (cyc[1] && cyc[0]);

  always @(posedge clk) begin
    cyc <= cyc + 4'd1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[6:2]];
    end else if (mem_rsp_valid && mem_rsp_ready) begin
      mem_rsp_valid <= 1'b0;
    end
    if (rst_n && reg_valid && reg_ready && n_log < 64) begin
      lg_a[n_log] <= reg_addr;
      lg_d[n_log] <= reg_data;
      n_log <= n_log + 1;
    end
  end

  function automatic logic [31:0] ent_a(int e); return 32'h0000_0100 + e; endfunction
  function automatic logic [31:0] ent_d(int e); return 32'hC0DE_0000 + e; endfunction
  function automatic logic [31:0] arm_bits(int c); return (32'd1 << c) | (32'd1 << (8 + c)); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic wait_done(string req, logic [31:0] mask);
    logic [31:0] st;
    st = '0;
    for (int i = 0; i < 600; i++) begin
      csr_rd(A_STAT, st);
      if ((st & mask) == mask) break;
    end
    check(req, st & mask, mask);
  endtask

  task automatic expect_writes(string req, int base, int first, int cnt);
    check(req, 32'(n_log - base), 32'(cnt));
    for (int i = 0; i < cnt; i++) begin
      if (base + i < n_log) begin
        check(req, lg_a[base + i], ent_a(first + i));
        check(req, lg_d[base + i], ent_d(first + i));
      end
    end
  endtask

  task automatic set_chan(int c, logic [31:0] s, logic [31:0] e);
    csr_wr(5'(c), s);
    csr_wr(5'(8 + c), e);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 21; a++) begin
      csr_rd(5'(a), v);
      check("R1 csr zero", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 valids", {30'd0, reg_valid, mem_req_valid}, 32'd0);
  endtask

  task automatic t_single();
    int base;
    logic [31:0] v;
    base = n_log;
    set_chan(0, 32'h00, 32'h0C);
    csr_wr(A_AUTO, arm_bits(0));
    pulse_vsync();
    wait_done("R2 ch0 done", 32'h01);
    repeat (4) @(negedge clk);
    expect_writes("R2 R4 two entries", base, 0, 2);
    check("R10 irq set", {31'd0, irq}, 32'd1);
    csr_wr(A_CTRL, 32'h01);
    csr_rd(A_STAT, v);
    check("R9 clear one", v, 32'd0);
    check("R10 irq drop", {31'd0, irq}, 32'd0);
    csr_wr(A_AUTO, 32'd0);
  endtask

  task automatic t_not_armed();
    int base;
    logic [31:0] v;
    base = n_log;
    set_chan(1, 32'h00, 32'h04);
    set_chan(7, 32'h00, 32'h04);
    csr_wr(A_AUTO, 32'd1 << 1);
    csr_wr(A_AUTO3, 32'd1);
    pulse_vsync();
    repeat (40) @(negedge clk);
    csr_rd(A_STAT, v);
    check("R3 trigger only no run", v, 32'd0);
    check("R3 trigger only no write", 32'(n_log - base), 32'd0);
    csr_wr(A_AUTO, 32'd0);
    csr_wr(A_AUTO3, 32'd0);
  endtask

  task automatic t_ch7();
    int base;
    base = n_log;
    set_chan(7, 32'h30, 32'h3C);
    csr_wr(A_AUTO2, 32'd1);
    csr_wr(A_AUTO3, 32'd1);
    pulse_vsync();
    wait_done("R3 ch7 done", 32'h80);
    repeat (4) @(negedge clk);
    expect_writes("R3 ch7 entries", base, 6, 2);
    check("R10 ch7 irq", {31'd0, irq}, 32'd1);
    csr_wr(A_AUTO2, 32'd0);
    csr_wr(A_AUTO3, 32'd0);
    csr_wr(A_CTRL, 32'hFF);
  endtask

  task automatic t_empty();
    int base;
    base = n_log;
    set_chan(2, 32'h40, 32'h3C);
    csr_wr(A_AUTO, arm_bits(2));
    pulse_vsync();
    wait_done("R4 empty done", 32'h04);
    repeat (4) @(negedge clk);
    check("R4 empty no write", 32'(n_log - base), 32'd0);
    csr_wr(A_AUTO, 32'd0);
    csr_wr(A_CTRL, 32'hFF);
  endtask

  task automatic t_extend();
    int base;
    base = n_log;
    set_chan(3, 32'h20, 32'h24);
    csr_wr(A_AUTO, arm_bits(3));
    csr_wr(5'd11, 32'h2C);
    pulse_vsync();
    wait_done("R5 extend done", 32'h08);
    repeat (4) @(negedge clk);
    expect_writes("R5 extended list", base, 4, 2);
    csr_wr(A_AUTO, 32'd0);
    csr_wr(A_CTRL, 32'hFF);
  endtask

  task automatic t_priority();
    int base;
    logic [31:0] v;
    base = n_log;
    bp_en = 1'b1;
    set_chan(5, 32'h30, 32'h3C);
    set_chan(4, 32'h20, 32'h2C);
    csr_wr(A_AUTO, arm_bits(4) | arm_bits(5));
    pulse_vsync();
    wait_done("R6 both done", 32'h30);
    repeat (8) @(negedge clk);
    expect_writes("R6 R11 low index first", base, 4, 4);
    csr_wr(A_CTRL, 32'hFF);
    csr_rd(A_STAT, v);
    check("R9 clear all", v, 32'd0);
    csr_wr(A_AUTO, 32'd0);
    bp_en = 1'b0;
  endtask

  task automatic t_busy();
    int base;
    base = n_log;
    bp_en = 1'b1;
    set_chan(0, 32'h00, 32'h1C);
    csr_wr(A_AUTO, arm_bits(0));
    pulse_vsync();
    for (int i = 0; i < 400 && n_log == base; i++) @(negedge clk);
    pulse_vsync();
    wait_done("R7 done", 32'h01);
    repeat (80) @(negedge clk);
    expect_writes("R7 vsync while busy ignored", base, 0, 4);
    csr_wr(A_AUTO, 32'd0);
    csr_wr(A_CTRL, 32'hFF);
    bp_en = 1'b0;
  endtask

  task automatic t_disarm();
    int base;
    base = n_log;
    bp_en = 1'b1;
    set_chan(6, 32'h00, 32'h1C);
    csr_wr(A_AUTO, arm_bits(6));
    pulse_vsync();
    for (int i = 0; i < 400 && n_log == base; i++) @(negedge clk);
    csr_wr(A_AUTO, 32'd1 << 14);
    wait_done("R8 finishes after disarm", 32'h40);
    repeat (4) @(negedge clk);
    expect_writes("R8 full list", base, 0, 4);
    check("R10 no irq without trigger", {31'd0, irq}, 32'd0);
    csr_wr(A_AUTO, 32'd0);
    csr_wr(A_CTRL, 32'hFF);
    bp_en = 1'b0;
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    csr_wr(A_CTRL, 32'h0000_03FF);
    csr_rd(A_CTRL, v);
    check("R12 urgent bits", v, 32'h0000_0300);
    csr_wr(A_CTRL, 32'h0000_0100);
    csr_rd(A_CTRL, v);
    check("R12 read urgent only", v, 32'h0000_0100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      mem[2*k]   = ent_a(k);
      mem[2*k+1] = ent_d(k);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_not_armed();
    t_ch7();
    t_empty();
    t_extend();
    t_priority();
    t_busy();
    t_disarm();
    t_ctrl();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule